// File: doc/BRIEF.md
# Program Flow and Return Stack Unit

This block owns the fetch address of a small microcontroller core with 12-bit instruction words. The execute stage shows it each instruction word along with the working register W, the status byte, the indirect-address byte and a skip request. The block then chooses the next fetch address: the next word in sequence, a branch target, an address popped from a hardware return stack, the address saved by the interrupt, or the interrupt vector. It keeps three page bits that extend the short branch targets into the full address space.

A change of flow leaves a word in the fetch path that was fetched but must not run. The block marks each such slot with `flush`, and the execute stage treats that word as a no-operation. In normal mode a jump, call, return or interrupt costs one such slot. In turbo mode it costs two. A taken skip always costs one slot.

On interrupt entry the block saves the return address, W, STATUS and the indirect-address byte. The return-from-interrupt words give these values back through one-cycle write strobes. One of them also asks for W to be added to the real-time counter. Subroutine returns can load a literal into W, leave W alone, or also restore the page bits that were saved with the call.

Top module: `flow_ctl`

## Requirements
- R1: While `rst` is high, `pc` is 0, `flush` is 1, all write strobes are 0 and the page bits are 0. The first word presented after reset is squashed.
- R2: An executed word that is not a flow instruction and has no skip advances `pc` by one on the next cycle, with `flush` low.
- R3: A word matching `101k kkkk kkkk` sets `pc` to {page bits, 9-bit k} on the next cycle.
- R4: A word matching `1001 kkkk kkkk` sets `pc` to {page bits, 0, 8-bit k}, so bit 8 of the target is always 0. It pushes the return address and the current page bits. The return address is the value `pc` held while the call was presented.
- R5: A word matching `0000 0001 0nnn` loads n into the page bits used by later jumps and calls, and advances `pc` by one.
- R6: A word matching `1000 kkkk kkkk` pops the stack into `pc` and pulses `w_load_en` with `w_load_val` = k.
- R7: Word 0x00C pops the stack into `pc`, does not pulse `w_load_en`, and leaves the page bits unchanged. Word 0x00D does the same but also reloads the page bits from the popped entry.
- R8: The stack holds 8 entries and returns them last-in first-out. A push onto a full stack overwrites the oldest entry. After 9 calls, 8 returns yield the 9th through 2nd return addresses.
- R9: After a jump, call, return or interrupt entry, `flush` is high for 1 cycle in normal mode (`turbo`=0) or 2 cycles in turbo mode. The target word executes in the cycle after that. A word presented while `flush` is high has no effect.
- R10: `skip_req` on an executed word squashes exactly one following slot in either mode: `pc` advances by one and `flush` is high for one cycle. `skip_req` is ignored while `flush` is high.
- R11: `irq_take` with `flush` low ignores the presented word and sets `pc` to the vector (0). It saves the ignored word's address (`pc`−1), W, STATUS and the indirect-address byte, and flushes like a jump.
- R12: Word 0x00E sets `pc` to the saved address. On the next cycle it pulses `w_load_en`, `status_wr_en` and `fsr_wr_en` with the saved values. STATUS bits 4 (time-out) and 3 (power-down) are taken from the current `status_in` and are not restored.
- R13: Word 0x00F behaves like 0x00E and also pulses `rtcc_add_en`, with `rtcc_add_val` equal to `w_in` at the time of the return.
- R14: Every write strobe lasts exactly one cycle. It appears in the cycle after its instruction, which is a squashed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| turbo | input | 1 | 1 selects the two-slot branch penalty |
| insn | input | 12 | Instruction word in the execute stage |
| skip_req | input | 1 | Execute stage asks to skip the next word |
| irq_take | input | 1 | Enter the interrupt at this word |
| w_in | input | 8 | Current W |
| status_in | input | 8 | Current STATUS |
| fsr_in | input | 8 | Current indirect-address byte |
| pc | output | 12 | Fetch address |
| flush | output | 1 | The word now presented must be squashed |
| w_load_en | output | 1 | Write `w_load_val` into W |
| w_load_val | output | 8 | Value for W |
| status_wr_en | output | 1 | Write `status_wr_val` into STATUS |
| status_wr_val | output | 8 | Restored STATUS |
| fsr_wr_en | output | 1 | Write `fsr_wr_val` into the indirect-address byte |
| fsr_wr_val | output | 8 | Restored indirect-address byte |
| rtcc_add_en | output | 1 | Add `rtcc_add_val` to the real-time counter |
| rtcc_add_val | output | 8 | W at the time of the timer-adjusting return |

## Verification
The properties assume that `irq_take` and `skip_req` are raised only while `flush` is low, and that a skip request never comes with a flow instruction. The bench follows this by raising skip only on no-operation words and interrupts only on executed slots. The properties also assume that returns never outnumber the calls and interrupts before them. The bench keeps to this by pairing every return with an earlier call or interrupt entry. No property relies on the contents of the stack beyond its depth. The wrap-around behaviour is checked only by the directed nine-call sequence.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int INSN_W = 12;
  localparam logic [INSN_W-1:0] NOP_WORD = 12'h000;
  // STATUS bits kept from the live value on interrupt return
  localparam int TO_BIT = 4;
  localparam int PD_BIT = 3;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_JUMP,
    OP_CALL,
    OP_RETLIT,
    OP_RET,
    OP_RETPG,
    OP_RETINT,
    OP_RETINT_T,
    OP_PAGE
  } flow_op_e;
endpackage

// File: rtl/flow_decode.sv
module flow_decode
  import flow_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  input  logic              kill,
  output flow_op_e          op
);
  always_comb begin
    op = OP_NONE;
    if (!kill) begin
      if (insn[11:9] == 3'b101)             op = OP_JUMP;
      else if (insn[11:8] == 4'b1001)       op = OP_CALL;
      else if (insn[11:8] == 4'b1000)       op = OP_RETLIT;
      else if (insn[11:3] == 9'b0000_0001_0) op = OP_PAGE;
      else if (insn == 12'h00C)             op = OP_RET;
      else if (insn == 12'h00D)             op = OP_RETPG;
      else if (insn == 12'h00E)             op = OP_RETINT;
      else if (insn == 12'h00F)             op = OP_RETINT_T;
      else                                  op = OP_NONE;
    end
  end
endmodule

// File: rtl/flow_rstack.sv
module flow_rstack #(
  parameter int DEPTH   = 8,
  parameter int ENTRY_W = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic               pop,
  input  logic [ENTRY_W-1:0] push_data,
  output logic [ENTRY_W-1:0] top_data
);
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [SP_W-1:0] LAST = SP_W'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]    sp;
  logic [SP_W-1:0]    rd_idx;
  logic [SP_W-1:0]    sp_inc;

  assign rd_idx   = (sp == '0) ? LAST : sp - 1'b1;
  assign sp_inc   = (sp == LAST) ? '0 : sp + 1'b1;
  assign top_data = mem[rd_idx];

  // Storage without reset so that distributed RAM can be inferred
  always_ff @(posedge clk) begin
    if (push) mem[sp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp_inc;
    else if (pop)  sp <= rd_idx;
  end
endmodule

// File: rtl/flow_isave.sv
module flow_isave #(
  parameter int PC_W   = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              save,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] w_in,
  input  logic [7:0]        status_in,
  input  logic [7:0]        fsr_in,
  output logic [PC_W-1:0]   saved_pc,
  output logic [DATA_W-1:0] saved_w,
  output logic [7:0]        saved_status,
  output logic [7:0]        saved_fsr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      saved_pc     <= '0;
      saved_w      <= '0;
      saved_status <= '0;
      saved_fsr    <= '0;
    end else if (save) begin
      saved_pc     <= pc_in;
      saved_w      <= w_in;
      saved_status <= status_in;
      saved_fsr    <= fsr_in;
    end
  end
endmodule

// File: rtl/flow_ctl.sv
module flow_ctl
  import flow_pkg::*;
#(
  parameter int PAGE_W   = 3,
  parameter int DEPTH    = 8,
  parameter int DATA_W   = 8,
  parameter int RESET_PC = 0,
  parameter int IRQ_PC   = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       turbo,
  input  logic [11:0]                insn,
  input  logic                       skip_req,
  input  logic                       irq_take,
  input  logic [DATA_W-1:0]          w_in,
  input  logic [7:0]                 status_in,
  input  logic [7:0]                 fsr_in,
  output logic [PAGE_W+8:0]          pc,
  output logic                       flush,
  output logic                       w_load_en,
  output logic [DATA_W-1:0]          w_load_val,
  output logic                       status_wr_en,
  output logic [7:0]                 status_wr_val,
  output logic                       fsr_wr_en,
  output logic [7:0]                 fsr_wr_val,
  output logic                       rtcc_add_en,
  output logic [DATA_W-1:0]          rtcc_add_val
);
  localparam int PC_W    = PAGE_W + 9;
  localparam int ENTRY_W = PC_W + PAGE_W;
  localparam logic [7:0] KEEP_MASK = 8'((1 << TO_BIT) | (1 << PD_BIT));

  flow_op_e            op;
  logic [1:0]          flush_cnt;
  logic [PAGE_W-1:0]   page_q;
  logic                irq_go, skip_go, is_ret, is_reti, xfer;
  logic [PC_W-1:0]     target, pc_next;
  logic [ENTRY_W-1:0]  top_entry;
  logic [PC_W-1:0]     saved_pc;
  logic [DATA_W-1:0]   saved_w;
  logic [7:0]          saved_status, saved_fsr;

  assign flush = (flush_cnt != 2'd0);

  flow_decode u_dec (
    .insn (insn),
    .kill (flush | irq_take),
    .op   (op)
  );

  assign irq_go  = irq_take & ~flush;
  assign is_ret  = (op == OP_RETLIT) | (op == OP_RET) | (op == OP_RETPG);
  assign is_reti = (op == OP_RETINT) | (op == OP_RETINT_T);
  assign xfer    = irq_go | is_ret | is_reti | (op == OP_JUMP) | (op == OP_CALL);
  assign skip_go = skip_req & ~flush & ~irq_take & ~xfer;

  flow_rstack #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (op == OP_CALL),
    .pop       (is_ret),
    .push_data ({page_q, pc}),
    .top_data  (top_entry)
  );

  flow_isave #(.PC_W(PC_W), .DATA_W(DATA_W)) u_save (
    .clk          (clk),
    .rst          (rst),
    .save         (irq_go),
    .pc_in        (PC_W'(pc - 1'b1)),
    .w_in         (w_in),
    .status_in    (status_in),
    .fsr_in       (fsr_in),
    .saved_pc     (saved_pc),
    .saved_w      (saved_w),
    .saved_status (saved_status),
    .saved_fsr    (saved_fsr)
  );

  always_comb begin
    target = pc;
    if (irq_go)                target = PC_W'(IRQ_PC);
    else if (op == OP_JUMP)    target = {page_q, insn[8:0]};
    else if (op == OP_CALL)    target = {page_q, 1'b0, insn[7:0]};
    else if (is_ret)           target = top_entry[PC_W-1:0];
    else if (is_reti)          target = saved_pc;
  end

  always_comb begin
    if (xfer)                  pc_next = target;
    else if (flush_cnt == 2'd2) pc_next = pc;
    else                       pc_next = pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= PC_W'(RESET_PC);
      flush_cnt <= 2'd1;
      page_q    <= '0;
    end else begin
      pc <= pc_next;
      if (xfer)                flush_cnt <= turbo ? 2'd2 : 2'd1;
      else if (skip_go)        flush_cnt <= 2'd1;
      else if (flush)          flush_cnt <= flush_cnt - 1'b1;
      if (op == OP_PAGE)       page_q <= insn[PAGE_W-1:0];
      else if (op == OP_RETPG) page_q <= top_entry[ENTRY_W-1:PC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_load_en     <= 1'b0;
      w_load_val    <= '0;
      status_wr_en  <= 1'b0;
      status_wr_val <= '0;
      fsr_wr_en     <= 1'b0;
      fsr_wr_val    <= '0;
      rtcc_add_en   <= 1'b0;
      rtcc_add_val  <= '0;
    end else begin
      w_load_en     <= (op == OP_RETLIT) | is_reti;
      w_load_val    <= (op == OP_RETLIT) ? DATA_W'(insn[7:0]) : saved_w;
      status_wr_en  <= is_reti;
      status_wr_val <= (saved_status & ~KEEP_MASK) | (status_in & KEEP_MASK);
      fsr_wr_en     <= is_reti;
      fsr_wr_val    <= saved_fsr;
      rtcc_add_en   <= (op == OP_RETINT_T);
      rtcc_add_val  <= w_in;
    end
  end
endmodule

// File: rtl/flow_ctl_chk.sv
module flow_ctl_chk #(
  parameter int PAGE_W = 3,
  parameter int DATA_W = 8,
  parameter int IRQ_PC = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              turbo,
  input logic [11:0]       insn,
  input logic              skip_req,
  input logic              irq_take,
  input logic [DATA_W-1:0] w_in,
  input logic [7:0]        status_in,
  input logic [PAGE_W+8:0] pc,
  input logic              flush,
  input logic              w_load_en,
  input logic [DATA_W-1:0] w_load_val,
  input logic              status_wr_en,
  input logic [7:0]        status_wr_val,
  input logic              rtcc_add_en,
  input logic [DATA_W-1:0] rtcc_add_val,
  input logic [PAGE_W-1:0] page_q
);
  localparam int PC_W = PAGE_W + 9;
  logic live, jmp;
  assign live = !flush && !irq_take;
  assign jmp  = live && (insn[11:9] == 3'b101);

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    live && !skip_req && insn == 12'h000 |=> !flush && pc == PC_W'($past(pc) + 1'b1));
  a_r3_jump_target: assert property (@(posedge clk) disable iff (rst)
    jmp |=> pc == {$past(page_q), $past(insn[8:0])});
  a_r4_call_bit8: assert property (@(posedge clk) disable iff (rst)
    live && insn[11:8] == 4'b1001 |=> flush && pc[8] == 1'b0);
  a_r6_retlit_w: assert property (@(posedge clk) disable iff (rst)
    live && insn[11:8] == 4'b1000 |=> w_load_en && w_load_val == DATA_W'($past(insn[7:0])));
  a_r7_ret_keeps_w: assert property (@(posedge clk) disable iff (rst)
    live && insn == 12'h00C |=> !w_load_en);
  a_r9_turbo_two: assert property (@(posedge clk) disable iff (rst)
    jmp && turbo |=> flush ##1 flush);
  a_r10_skip_one: assert property (@(posedge clk) disable iff (rst)
    live && skip_req && insn == 12'h000 |=> flush && pc == PC_W'($past(pc) + 1'b1));
  a_r11_irq_vec: assert property (@(posedge clk) disable iff (rst)
    irq_take && !flush |=> flush && pc == PC_W'(IRQ_PC));
  a_r12_tp_kept: assert property (@(posedge clk) disable iff (rst)
    live && insn[11:1] == 11'h007 |=> status_wr_en && status_wr_val[4:3] == $past(status_in[4:3]));
  a_r13_timer_add: assert property (@(posedge clk) disable iff (rst)
    live && insn == 12'h00F |=> rtcc_add_en && rtcc_add_val == $past(w_in));
  a_r14_strobe_slot: assert property (@(posedge clk) disable iff (rst)
    w_load_en || status_wr_en || rtcc_add_en |-> flush);
endmodule

bind flow_ctl flow_ctl_chk #(.PAGE_W(PAGE_W), .DATA_W(DATA_W), .IRQ_PC(IRQ_PC)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .turbo         (turbo),
  .insn          (insn),
  .skip_req      (skip_req),
  .irq_take      (irq_take),
  .w_in          (w_in),
  .status_in     (status_in),
  .pc            (pc),
  .flush         (flush),
  .w_load_en     (w_load_en),
  .w_load_val    (w_load_val),
  .status_wr_en  (status_wr_en),
  .status_wr_val (status_wr_val),
  .rtcc_add_en   (rtcc_add_en),
  .rtcc_add_val  (rtcc_add_val),
  .page_q        (page_q)
);

// File: tb/test_flow_ctl.sv
module test_flow_ctl;
  logic        clk = 1'b0;
  logic        rst, turbo, skip_req, irq_take;
  logic [11:0] insn;
  logic [7:0]  w_in, status_in, fsr_in;
  logic [11:0] pc;
  logic        flush, w_load_en, status_wr_en, fsr_wr_en, rtcc_add_en;
  logic [7:0]  w_load_val, status_wr_val, fsr_wr_val, rtcc_add_val;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flow_ctl i_flow_ctl (
    .clk(clk), .rst(rst), .turbo(turbo), .insn(insn), .skip_req(skip_req),
    .irq_take(irq_take), .w_in(w_in), .status_in(status_in), .fsr_in(fsr_in),
    .pc(pc), .flush(flush), .w_load_en(w_load_en), .w_load_val(w_load_val),
    .status_wr_en(status_wr_en), .status_wr_val(status_wr_val),
    .fsr_wr_en(fsr_wr_en), .fsr_wr_val(fsr_wr_val),
    .rtcc_add_en(rtcc_add_en), .rtcc_add_val(rtcc_add_val)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one word at the falling edge, return at the next falling edge
  task automatic issue(logic [11:0] w, bit sk = 0, bit irq = 0);
    insn = w; skip_req = sk; irq_take = irq;
    @(posedge clk);
    @(negedge clk);
    insn = 12'h000; skip_req = 0; irq_take = 0;
  endtask

  task automatic settle();
    while (flush) issue(12'h000);
  endtask

  task automatic t_reset();
    rst = 1; turbo = 0; insn = 0; skip_req = 0; irq_take = 0;
    w_in = 0; status_in = 0; fsr_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", pc, 0);
    chk("R1 flush", flush, 1);
    chk("R1 strobes", {w_load_en, status_wr_en, fsr_wr_en, rtcc_add_en}, 0);
    rst = 0;
    issue(12'hA55);
    chk("R1 first slot squashed pc", pc, 1);
    chk("R1 flush clears", flush, 0);
  endtask

  task automatic t_page_jump();
    logic [11:0] p = pc;
    issue(12'h000);
    chk("R2 step", pc, p + 1);
    chk("R2 no flush", flush, 0);
    issue(12'h015);
    chk("R5 page word steps", pc, p + 2);
    issue(12'hB23);
    chk("R3 jump target", pc, 12'hB23);
    chk("R9 flush after jump", flush, 1);
    issue(12'hA10);
    chk("R9 squashed jump ignored", pc, 12'hB24);
    chk("R9 one slot normal", flush, 0);
  endtask

  task automatic t_turbo();
    turbo = 1;
    issue(12'hA07);
    chk("R9 turbo target", pc, 12'hA07);
    chk("R9 turbo slot1", flush, 1);
    issue(12'hA10);
    chk("R9 turbo hold", pc, 12'hA07);
    chk("R9 turbo slot2", flush, 1);
    issue(12'h000);
    chk("R9 turbo resume", pc, 12'hA08);
    chk("R9 turbo done", flush, 0);
    turbo = 0;
  endtask

  task automatic t_call_retlit();
    logic [11:0] r;
    issue(12'h010);
    r = pc;
    issue(12'h942);
    chk("R4 call target", pc, 12'h042);
    settle();
    issue(12'h8A5);
    chk("R6 return pc", pc, r);
    chk("R6 w load", w_load_en, 1);
    chk("R6 literal", w_load_val, 8'hA5);
    chk("R14 strobe in squashed slot", flush, 1);
    issue(12'h000);
    chk("R14 single pulse", w_load_en, 0);
  endtask

  task automatic t_ret_page();
    logic [11:0] r;
    issue(12'h013);
    r = pc;
    issue(12'h9FF);
    chk("R4 call bit8 clear", pc, 12'h6FF);
    settle();
    issue(12'h011);
    issue(12'h00D);
    chk("R7 page return pc", pc, r);
    chk("R7 page return keeps W", w_load_en, 0);
    settle();
    issue(12'hA00);
    chk("R7 page bits restored", pc, 12'h600);
    settle();
    issue(12'h012);
    r = pc;
    issue(12'h910);
    chk("R4 call with page", pc, 12'h410);
    settle();
    issue(12'h016);
    issue(12'h00C);
    chk("R7 plain return pc", pc, r);
    chk("R7 plain return keeps W", w_load_en, 0);
    settle();
    issue(12'hA00);
    chk("R7 page bits kept", pc, 12'hC00);
    settle();
  endtask

  task automatic t_stack();
    logic [11:0] rets [9];
    issue(12'h010);
    for (int i = 0; i < 9; i++) begin
      rets[i] = pc;
      issue(12'h900 | 12'(8'h20 + i));
      chk("R4 nested call", pc, 12'h020 + 12'(i));
      settle();
    end
    for (int i = 8; i >= 1; i--) begin
      issue(12'h00C);
      chk("R8 stack order", pc, rets[i]);
      settle();
    end
  endtask

  task automatic t_skip();
    logic [11:0] p = pc;
    issue(12'h000, 1);
    chk("R10 skip pc", pc, p + 1);
    chk("R10 skip flush", flush, 1);
    issue(12'h000, 1);
    chk("R10 skip in slot ignored", flush, 0);
    chk("R10 skip in slot pc", pc, p + 2);
    turbo = 1;
    p = pc;
    issue(12'h000, 1);
    chk("R10 turbo skip flush", flush, 1);
    issue(12'h000);
    chk("R10 turbo skip one slot", flush, 0);
    chk("R10 turbo skip pc", pc, p + 2);
    turbo = 0;
  endtask

  task automatic t_irq();
    logic [11:0] p = pc;
    w_in = 8'h3C; status_in = 8'hA7; fsr_in = 8'h55;
    issue(12'hA33, 0, 1);
    chk("R11 vector, word ignored", pc, 12'h000);
    chk("R11 flush", flush, 1);
    settle();
    w_in = 8'h11; status_in = 8'h18; fsr_in = 8'h00;
    issue(12'h00E);
    chk("R12 return address", pc, p - 1);
    chk("R12 w strobe", w_load_en, 1);
    chk("R12 w value", w_load_val, 8'h3C);
    chk("R12 status strobe", status_wr_en, 1);
    chk("R12 status keeps TO PD", status_wr_val, 8'hBF);
    chk("R12 fsr", {fsr_wr_en, fsr_wr_val}, {1'b1, 8'h55});
    chk("R12 no timer add", rtcc_add_en, 0);
    settle();
  endtask

  task automatic t_retiw();
    logic [11:0] p = pc;
    w_in = 8'h20;
    issue(12'h000, 0, 1);
    settle();
    w_in = 8'h09;
    issue(12'h00F);
    chk("R13 return address", pc, p - 1);
    chk("R13 timer add", {rtcc_add_en, rtcc_add_val}, {1'b1, 8'h09});
    chk("R13 saved w", w_load_val, 8'h20);
    issue(12'h000);
    chk("R14 timer pulse ends", rtcc_add_en, 0);
  endtask

  initial begin
    t_reset();
    t_page_jump();
    t_turbo();
    t_call_retlit();
    t_ret_page();
    t_stack();
    t_skip();
    t_irq();
    t_retiw();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule